// File: doc/BRIEF.md
# Multi-Cycle AES-128 Block Encryptor

This block encrypts a single 128-bit plaintext block under a 128-bit cipher key using AES-128. It is built for area rather than speed. One state register, one bank of sixteen byte substitution lookups, one row rotator and one four-column mixing network are reused for every round. A small sequencer walks them through the round operations one stage per clock.

The byte substitution lookups behave like synchronous memories: the result of a lookup appears one clock after its address. The sequencer therefore spends a dedicated wait cycle after each lookup. The round key generator is instantiated inside the block. It derives each next round key from the current one in step with the rounds, through four lookups of the same synchronous kind.

A host places the key and plaintext on the inputs and pulses the load strobe. It then watches the done flag, and reads the ciphertext while the flag is high.

Top module: `aes_mc_engine`

## Requirements
- R1: While reset is high and on the first cycle after it is released, done is low.
- R2: Byte 0 of a 128-bit block is bits [127:120]. The state is held column-major, so byte i sits in row i mod 4 of column i div 4. The ciphertext is the standard AES-128 result. For example, key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: The encryption order is fixed:
  - the cipher key is XORed into the plaintext;
  - nine rounds of substitution, row rotation (row r rotated left by r bytes), column mixing and round key addition follow;
  - a tenth round runs the same way but without column mixing.
- R4: Every substitution issue cycle is followed by exactly one wait cycle, and the substituted bytes are taken in that wait cycle.
- R5: When load is sampled high in an idle cycle, done is seen high after the 49th rising edge that follows the sampling edge.
- R6: Once done is high, it and the ciphertext stay unchanged until the next load, whatever the key and plaintext inputs do.
- R7: A load that arrives while an encryption is in progress is ignored. The running encryption finishes with its original result and its original latency.
- R8: A load accepted while done is high clears done on the next edge and starts a new encryption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start strobe for a new block; sampled only when idle |
| key | input | 128 | Cipher key, byte 0 in the top bits |
| plaintext | input | 128 | Plaintext block, byte 0 in the top bits |
| ciphertext | output | 128 | Encrypted block, valid while done is high |
| done | output | 1 | High from completion until the next accepted load |

## Verification
The bench builds the block with its default of ten rounds, which is exactly the AES-128 schedule. This lets the published test vectors and an independent reference encryptor in the bench judge every result. The round-constant sequence up to its tenth value, and the skip of column mixing in the last round, are both covered by those comparisons. Fixed-seed random keys and plaintexts are mixed with all-zero and all-one blocks. Loads injected mid-encryption and loads issued while done is high cover the sequencing corners.

// File: rtl/aes_mc_pkg.sv
`timescale 1ns/1ps
package aes_mc_pkg;

    localparam int BLK_W  = 128;
    localparam int NBYTES = BLK_W / 8;
    localparam int NCOLS  = 4;
    localparam int COL_W  = BLK_W / NCOLS;

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SUB, ST_WAIT, ST_SHIFT, ST_MIX, ST_ADD
    } phase_e;

    // multiply by x in GF(2^8), reduction polynomial 0x11b
    function automatic byte_t xt(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t acc = 8'h00;
        byte_t x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = xt(x);
        end
        return acc;
    endfunction

    // a^254 via repeated squaring: a^2 * a^4 * ... * a^128
    function automatic byte_t ginv(input byte_t a);
        byte_t p = a;
        byte_t r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t b, input int n);
        byte_t v = b;
        for (int i = 0; i < 8; i++)
            if (i < n) v = {v[6:0], v[7]};
        return v;
    endfunction

    function automatic byte_t sbox_f(input byte_t a);
        byte_t b = ginv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // row r of the column-major state rotated left by r positions
    function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s);
        logic [BLK_W-1:0] o;
        for (int c = 0; c < NCOLS; c++)
            for (int r = 0; r < 4; r++)
                o[BLK_W-1-8*(c*4+r) -: 8] = s[BLK_W-1-8*(((c+r)%4)*4+r) -: 8];
        return o;
    endfunction

    function automatic byte_t rcon_f(input logic [7:0] n);
        byte_t r = 8'h01;
        for (int i = 1; i < 16; i++)
            if (i < int'(n)) r = xt(r);
        return r;
    endfunction

endpackage

// File: rtl/aes_sub_bank.sv
`timescale 1ns/1ps
module aes_sub_bank #(
    parameter int LANES = 16
) (
    input  logic               clk,
    input  logic [8*LANES-1:0] addr,
    output logic [8*LANES-1:0] data
);
    import aes_mc_pkg::*;

    // each lane behaves as a synchronous lookup memory: one-cycle read latency
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            data[8*g +: 8] <= sbox_f(addr[8*g +: 8]);
        end
    end
endmodule

// File: rtl/aes_mix_cols.sv
`timescale 1ns/1ps
module aes_mix_col (
    input  logic [31:0] col,
    output logic [31:0] mixed
);
    import aes_mc_pkg::*;

    byte_t a [4];
    for (genvar i = 0; i < 4; i++) begin : g_in
        assign a[i] = col[31-8*i -: 8];
    end

    for (genvar i = 0; i < 4; i++) begin : g_out
        assign mixed[31-8*i -: 8] = gmul(a[i], 8'h02) ^ gmul(a[(i+1)%4], 8'h03)
                                  ^ a[(i+2)%4] ^ a[(i+3)%4];
    end
endmodule

module aes_mix_cols (
    input  logic [aes_mc_pkg::BLK_W-1:0] st,
    output logic [aes_mc_pkg::BLK_W-1:0] mixed
);
    import aes_mc_pkg::*;

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        aes_mix_col u_col (
            .col   (st[BLK_W-1-COL_W*c -: COL_W]),
            .mixed (mixed[BLK_W-1-COL_W*c -: COL_W])
        );
    end
endmodule

// File: rtl/aes_key_step.sv
`timescale 1ns/1ps
module aes_key_step (
    input  logic         clk,
    input  logic [127:0] rk,
    input  logic [7:0]   rcon,
    output logic [127:0] rk_next
);
    logic [31:0] w0, w1, w2, w3, rot, sub, t, n0, n1, n2, n3;

    assign {w0, w1, w2, w3} = rk;
    assign rot = {w3[23:0], w3[31:24]};

    // lookup issued while rk is stable; result valid the following cycle
    aes_sub_bank #(.LANES(4)) u_sub (
        .clk  (clk),
        .addr (rot),
        .data (sub)
    );

    assign t  = sub ^ {rcon, 24'h000000};
    assign n0 = w0 ^ t;
    assign n1 = w1 ^ n0;
    assign n2 = w2 ^ n1;
    assign n3 = w3 ^ n2;
    assign rk_next = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_mc_engine.sv
`timescale 1ns/1ps
module aes_mc_engine #(
    parameter int ROUNDS = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [127:0] key,
    input  logic [127:0] plaintext,
    output logic [127:0] ciphertext,
    output logic         done
);
    import aes_mc_pkg::*;

    localparam int RW = $clog2(ROUNDS + 1);
    localparam logic [RW-1:0] LAST = RW'(ROUNDS);

    phase_e         ph;
    logic [RW-1:0]  rnd;
    logic [127:0]   st, rk, sub_out, key_next, shifted, mixed;

    aes_sub_bank #(.LANES(NBYTES)) u_sub (
        .clk  (clk),
        .addr (st),
        .data (sub_out)
    );

    aes_key_step u_key (
        .clk     (clk),
        .rk      (rk),
        .rcon    (rcon_f(8'(rnd))),
        .rk_next (key_next)
    );

    assign shifted = shift_rows(st);

    aes_mix_cols u_mix (
        .st    (st),
        .mixed (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= ST_IDLE;
            rnd  <= '0;
            st   <= '0;
            rk   <= '0;
            done <= 1'b0;
        end else begin
            case (ph)
                ST_IDLE: if (load) begin
                    st   <= plaintext ^ key;
                    rk   <= key;
                    rnd  <= RW'(1);
                    done <= 1'b0;
                    ph   <= ST_SUB;
                end
                ST_SUB:  ph <= ST_WAIT;
                ST_WAIT: begin
                    st <= sub_out;
                    rk <= key_next;
                    ph <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    st <= shifted;
                    ph <= (rnd == LAST) ? ST_ADD : ST_MIX;
                end
                ST_MIX: begin
                    st <= mixed;
                    ph <= ST_ADD;
                end
                ST_ADD: begin
                    st <= st ^ rk;
                    if (rnd == LAST) begin
                        done <= 1'b1;
                        ph   <= ST_IDLE;
                    end else begin
                        rnd <= rnd + RW'(1);
                        ph  <= ST_SUB;
                    end
                end
                default: ph <= ST_IDLE;
            endcase
        end
    end

    assign ciphertext = st;

    // R4: a lookup issue is always followed by its wait cycle
    a_r4_wait_after_sub: assert property (@(posedge clk) disable iff (rst)
        (ph == ST_SUB) |=> (ph == ST_WAIT));

    // R3: the last round goes straight from row rotation to key addition
    a_r3_final_skips_mix: assert property (@(posedge clk) disable iff (rst)
        (ph == ST_SHIFT && rnd == LAST) |=> (ph == ST_ADD));

    // R5: done only rises out of the last key addition
    a_r5_done_from_final: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(ph) == ST_ADD && $past(rnd) == LAST));

    // R6: result and flag hold until a load
    a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> (done && $stable(ciphertext)));

    // R7: a busy engine never restarts at round one
    a_r7_busy_load_ignored: assert property (@(posedge clk) disable iff (rst)
        (ph != ST_IDLE) |=> !(ph == ST_SUB && rnd == RW'(1)));

    // R8: an idle load clears done and begins substitution
    a_r8_load_clears_done: assert property (@(posedge clk) disable iff (rst)
        (ph == ST_IDLE && load) |=> (!done && ph == ST_SUB));

endmodule

// File: tb/tb_aes_mc_engine.sv
`timescale 1ns/1ps
module tb_aes_mc_engine;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] plaintext = '0;
    logic [127:0] ciphertext;
    logic         done;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] sb [256];

    aes_mc_engine dut (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .key        (key),
        .plaintext  (plaintext),
        .ciphertext (ciphertext),
        .done       (done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] acc = '0;
        for (int i = 0; i < 8; i++)
            if (b[i]) acc = acc ^ ({8'h00, a} << i);
        for (int i = 15; i >= 8; i--)
            if (acc[i]) acc = acc ^ (16'h011b << (i - 8));
        return acc[7:0];
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
        logic [31:0] w [44];
        logic [31:0] tmp;
        logic [7:0]  rc = 8'h01;
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [127:0] o;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
                rc = fmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int row = 0; row < 4; row++)
                    t[c*4+row] = s[((c+row)%4)*4+row];
            for (int c = 0; c < 4; c++)
                for (int j = 0; j < 4; j++)
                    if (r < 10)
                        s[c*4+j] = fmul(t[c*4+j], 8'h02) ^ fmul(t[c*4+(j+1)%4], 8'h03)
                                 ^ t[c*4+(j+2)%4] ^ t[c*4+(j+3)%4];
                    else
                        s[c*4+j] = t[c*4+j];
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*r + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    // starts one encryption; optionally injects a busy load at cycle inj
    task automatic run(input logic [127:0] k, input logic [127:0] p, input int inj,
                       output logic [127:0] ct, output int lat);
        @(negedge clk);
        key = k; plaintext = p; load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        chk(done == 1'b0, "R8", "done cleared after load", {127'b0, done}, 128'h0);
        lat = 0;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == inj) begin
                key = ~k; plaintext = p ^ 128'h5a5a; load = 1'b1;
            end else if (lat == inj + 1) begin
                load = 1'b0; key = k; plaintext = p;
            end
        end
        ct = ciphertext;
    endtask

    task automatic vec(input logic [127:0] k, input logic [127:0] p,
                       input logic [127:0] exp, input string req);
        logic [127:0] ct;
        int lat;
        run(k, p, -5, ct, lat);
        chk(ct == exp, req, "ciphertext", ct, exp);
        chk(lat == 49, "R5", "latency", 128'(lat), 128'd49);
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] ct, hold, k, p;
        logic [7:0] inv;
        int lat;
        void'($urandom(32'h0c0ffee1));
        for (int x = 0; x < 256; x++) begin
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (fmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                sb[x][i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                         ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
        end

        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done during reset", {127'b0, done}, 128'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", {127'b0, done}, 128'h0);

        vec(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2");
        vec(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
            128'h3925841d02dc09fbdc118597196a0b32, "R3");
        vec(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R2");
        vec({128{1'b1}}, {128{1'b1}}, ref_enc({128{1'b1}}, {128{1'b1}}), "R3");

        // R6: hold while inputs wander
        hold = ciphertext;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            key = {4{$urandom}}; plaintext = {4{$urandom}};
        end
        @(negedge clk);
        chk(done == 1'b1, "R6", "done held", {127'b0, done}, 128'h1);
        chk(ciphertext == hold, "R6", "ciphertext held", ciphertext, hold);

        // R7: loads during encryption are ignored
        for (int inj = 3; inj < 48; inj += 11) begin
            k = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            run(k, p, inj, ct, lat);
            chk(ct == ref_enc(k, p), "R7", "result after busy load", ct, ref_enc(k, p));
            chk(lat == 49, "R7", "latency after busy load", 128'(lat), 128'd49);
        end

        // R2/R4: random blocks, every round's substitution timing exercised
        for (int i = 0; i < 24; i++) begin
            k = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            vec(k, p, ref_enc(k, p), "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule